// File: doc/BRIEF.md
# 4:2:2 Packer with Timing Reference Insertion

This block sits after a colour-space converter and turns a full-rate YCbCr 4:4:4 pixel stream into a 4:2:2 stream carried on two 8-bit buses. The luma bus repeats the Y sample of every active pixel. The chroma bus takes the blue-difference and red-difference samples in turn, starting over with blue-difference at the first active pixel of each line. The block adds one register stage, so each output word appears on the clock edge after its input.

While either blanking flag is high, the block sends fixed words instead of pixels. Each horizontal blanking interval begins with a four-word end-of-active-video marker and ends with a four-word start-of-active-video marker. Each marker has the form FF 00 00 XY. The last word of the marker says whether the line is entering or leaving vertical blanking. The cycles between the markers, and the non-horizontal part of vertical blanking lines, carry a filler that alternates between two levels. The interval length is the parameter `HBL`, so the start marker is placed by counting and needs no look-ahead on the inputs.

The inputs must follow a fixed timing. `hblank_i` is high for exactly `HBL` cycles per line, with `HBL` of at least 8. `vblank_i` changes only in the cycle where `hblank_i` rises. All outputs stay zero until the first high-to-low transition of `vblank_i` after reset.

Top module: `ycc422_packer`

## Requirements
- R1: From reset until the first cycle in which `vblank_i` is low after being high, both outputs are 0x00 whatever the other inputs are. The output for that falling cycle itself is produced normally.
- R2: For every active input cycle (`hblank_i` = 0 and `vblank_i` = 0), `yo_o` equals that cycle's `y_i` one clock later.
- R3: On active cycles, `co_o` (one clock later) carries `cb_i` on the first active cycle of a line and then alternates, giving Cr, Cb, Cr, and so on, until the line's active region ends.
- R4: Blanking position 0 is the cycle in which `hblank_i` rises. Positions 0 to 3 of each horizontal blanking interval produce FF, 00, 00, XY on both buses.
- R5: Positions HBL-4 to HBL-1 of each horizontal blanking interval produce FF, 00, 00, XY on both buses. The first active pixel follows immediately after.
- R6: The XY word of the leading marker is 0xB6 if `vblank_i` rose in the same cycle as `hblank_i`, and 0x9D otherwise. The XY word of the trailing marker is 0xAB if `vblank_i` fell at the start of that interval, and 0x80 otherwise. The vertical code wins whenever both transitions coincide.
- R7: Every other blanking cycle produces 0x80 on both buses when the blanking position is even and 0x10 when it is odd. The position keeps counting through the non-horizontal part of vertical blanking lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| y_i | input | 8 | Luma sample, 4:4:4 |
| cb_i | input | 8 | Blue-difference sample, 4:4:4 |
| cr_i | input | 8 | Red-difference sample, 4:4:4 |
| hblank_i | input | 1 | Horizontal blanking, active high |
| vblank_i | input | 1 | Vertical blanking, active high |
| yo_o | output | 8 | Luma / timing word output |
| co_o | output | 8 | Alternating chroma / timing word output |

## Verification
A wrong blanking position count shows up within one line. The start marker would appear on the wrong cycles, or the filler would swap its two levels. Either error reaches the buses on the very next edge. A stale vertical-transition flag gives a wrong XY word in the first marker that follows, and a chroma phase that is not restarted makes the first pixel of the next line carry Cr instead of Cb. The scoreboard compares every output word of two full vertical-blanking cycles against a model built from the requirements, so each of these errors is caught at the first word it corrupts.

// File: rtl/ycc422_pkg.sv
package ycc422_pkg;
  localparam logic [7:0] TRS_LEAD   = 8'hFF;
  localparam logic [7:0] TRS_ZERO   = 8'h00;
  localparam logic [7:0] XY_V_ENTER = 8'hB6;
  localparam logic [7:0] XY_V_LEAVE = 8'hAB;
  localparam logic [7:0] XY_H_ENTER = 8'h9D;
  localparam logic [7:0] XY_H_LEAVE = 8'h80;
  localparam logic [7:0] FILL_EVEN  = 8'h80;
  localparam logic [7:0] FILL_ODD   = 8'h10;

  // word of a four-slot timing marker: lead, zero, zero, position code
  function automatic logic [7:0] trs_word(input logic [1:0] slot, input logic [7:0] xy);
    logic [7:0] w;
    case (slot)
      2'd0:    w = TRS_LEAD;
      2'd3:    w = xy;
      default: w = TRS_ZERO;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/ycc422_blank_tracker.sv
module ycc422_blank_tracker #(
  parameter int HBL = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hblank_i,
  input  logic                      vblank_i,
  output logic                      en_o,
  output logic [$clog2(HBL):0]      pos_o,
  output logic                      vrise_o,
  output logic                      vfall_o
);
  localparam int CW = $clog2(HBL) + 1;

  logic          hb_q, vb_q, armed_q, vr_q, vf_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hb_rise, vb_fall, blank, cnt_en;

  always_comb begin
    hb_rise = hblank_i & ~hb_q;
    vb_fall = vb_q & ~vblank_i;
    blank   = hblank_i | vblank_i;
    pos_o   = hb_rise ? '0 : cnt_q;
    cnt_d   = blank ? pos_o + 1'b1 : '0;
    cnt_en  = blank | (cnt_q != '0);
    vrise_o = hb_rise ? (vblank_i & ~vb_q) : vr_q;
    vfall_o = hb_rise ? vb_fall : vf_q;
    en_o    = armed_q | vb_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_q    <= 1'b0;
      vb_q    <= 1'b0;
      armed_q <= 1'b0;
      vr_q    <= 1'b0;
      vf_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      hb_q <= hblank_i;
      vb_q <= vblank_i;
      if (vb_fall) armed_q <= 1'b1;
      if (hb_rise) begin
        vr_q <= vrise_o;
        vf_q <= vfall_o;
      end
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ycc422_chroma_phase.sv
module ycc422_chroma_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic sel_cr_o
);
  logic ph_q, ph_d, ph_en;

  always_comb begin
    ph_d     = active_i ? ~ph_q : 1'b0;
    ph_en    = active_i | ph_q;
    sel_cr_o = ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= 1'b0;
    else if (ph_en) ph_q <= ph_d;
  end
endmodule

// File: rtl/ycc422_packer.sv
module ycc422_packer
  import ycc422_pkg::*;
#(
  parameter int HBL = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] y_i,
  input  logic [7:0] cb_i,
  input  logic [7:0] cr_i,
  input  logic       hblank_i,
  input  logic       vblank_i,
  output logic [7:0] yo_o,
  output logic [7:0] co_o
);
  localparam int CW = $clog2(HBL) + 1;
  localparam logic [CW-1:0] SAV_FIRST = CW'(HBL - 4);
  localparam logic [CW-1:0] SAV_END   = CW'(HBL);

  logic [1:0]    rs_q;
  logic          rst_core_n;
  logic          en, vrise, vfall, sel_cr, active;
  logic [CW-1:0] pos, sav_off;
  logic          in_eav, in_sav;
  logic [7:0]    xy_eav, xy_sav, fill, yo_d, co_d, yo_q, co_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  ycc422_blank_tracker #(.HBL(HBL)) u_track (
    .clk(clk), .rst_n(rst_core_n), .hblank_i(hblank_i), .vblank_i(vblank_i),
    .en_o(en), .pos_o(pos), .vrise_o(vrise), .vfall_o(vfall)
  );

  ycc422_chroma_phase u_phase (
    .clk(clk), .rst_n(rst_core_n), .active_i(active), .sel_cr_o(sel_cr)
  );

  always_comb begin
    active  = ~hblank_i & ~vblank_i;
    sav_off = pos - SAV_FIRST;
    in_eav  = hblank_i && (pos < CW'(4));
    in_sav  = hblank_i && (pos >= SAV_FIRST) && (pos < SAV_END);
    xy_eav  = vrise ? XY_V_ENTER : XY_H_ENTER;
    xy_sav  = vfall ? XY_V_LEAVE : XY_H_LEAVE;
    fill    = pos[0] ? FILL_ODD : FILL_EVEN;
    if (!en) begin
      yo_d = 8'h00;
      co_d = 8'h00;
    end else if (active) begin
      yo_d = y_i;
      co_d = sel_cr ? cr_i : cb_i;
    end else if (in_eav) begin
      yo_d = trs_word(pos[1:0], xy_eav);
      co_d = yo_d;
    end else if (in_sav) begin
      yo_d = trs_word(sav_off[1:0], xy_sav);
      co_d = yo_d;
    end else begin
      yo_d = fill;
      co_d = fill;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      yo_q <= 8'h00;
      co_q <= 8'h00;
    end else begin
      yo_q <= yo_d;
      co_q <= co_d;
    end
  end

  assign yo_o = yo_q;
  assign co_o = co_q;
endmodule

// File: rtl/ycc422_packer_chk.sv
module ycc422_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] y_i,
  input logic [7:0] cb_i,
  input logic       hblank_i,
  input logic       vblank_i,
  input logic [7:0] yo_o,
  input logic [7:0] co_o
);
  logic hb_d, vb_d, seen_q, fall_now, en_now, act_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_d   <= 1'b0;
      vb_d   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      hb_d <= hblank_i;
      vb_d <= vblank_i;
      if (fall_now) seen_q <= 1'b1;
    end
  end

  assign fall_now = vb_d & ~vblank_i;
  assign en_now   = seen_q | fall_now;
  assign act_now  = ~hblank_i & ~vblank_i;

  assert_quiet_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_now |=> (yo_o == 8'h00 && co_o == 8'h00));

  assert_luma_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_now && act_now) |=> (yo_o == $past(y_i)));

  assert_line_starts_cb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_now && act_now && (hb_d || vb_d)) |=> (co_o == $past(cb_i)));

  assert_eav_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_now && hblank_i && !hb_d) |=> (yo_o == 8'hFF && co_o == 8'hFF));

  assert_vfill_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_now && vblank_i && !hblank_i) |=> ((yo_o == 8'h80 || yo_o == 8'h10) && co_o == yo_o));
endmodule

bind ycc422_packer ycc422_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .y_i(y_i), .cb_i(cb_i),
  .hblank_i(hblank_i), .vblank_i(vblank_i), .yo_o(yo_o), .co_o(co_o)
);

// File: tb/tb_ycc422_packer.sv
module tb_ycc422_packer;
  localparam int CLK_PERIOD = 10;
  localparam int HBL = 16;
  localparam int ACT = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] y_i = '0, cb_i = '0, cr_i = '0;
  logic       hblank_i = 1'b0, vblank_i = 1'b0;
  logic [7:0] yo_o, co_o;

  ycc422_packer #(.HBL(HBL)) dut (
    .clk(clk), .rst_n(rst_n), .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i),
    .hblank_i(hblank_i), .vblank_i(vblank_i), .yo_o(yo_o), .co_o(co_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [7:0] y; logic [7:0] c; string req; } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state, built from the requirements
  bit m_hb = 0, m_vb = 0, m_armed = 0, m_vr = 0, m_vf = 0, m_ph = 0;
  int m_pos = 0;

  function automatic logic [7:0] marker(int slot, logic [7:0] xy);
    if (slot == 0) return 8'hFF;
    if (slot == 3) return xy;
    return 8'h00;
  endfunction

  task automatic step(bit hb, bit vb, logic [7:0] y, logic [7:0] cb, logic [7:0] cr);
    exp_t e;
    bit rise, vrise, vfall, en, act;
    int pos;
    @(negedge clk);
    rise  = hb && !m_hb;
    vrise = vb && !m_vb;
    vfall = !vb && m_vb;
    pos   = rise ? 0 : m_pos;
    if (rise) begin m_vr = vrise; m_vf = vfall; end
    en  = m_armed || vfall;
    act = !hb && !vb;
    if (!en) begin
      e.y = 8'h00; e.c = 8'h00; e.req = "R1";
    end else if (act) begin
      e.y = y; e.c = m_ph ? cr : cb; e.req = "R2,R3";
    end else if (hb && pos < 4) begin
      e.y = marker(pos, m_vr ? 8'hB6 : 8'h9D); e.c = e.y;
      e.req = (pos == 3) ? "R6" : "R4";
    end else if (hb && pos >= HBL-4 && pos < HBL) begin
      e.y = marker(pos-(HBL-4), m_vf ? 8'hAB : 8'h80); e.c = e.y;
      e.req = (pos == HBL-1) ? "R6" : "R5";
    end else begin
      e.y = (pos % 2 == 1) ? 8'h10 : 8'h80; e.c = e.y; e.req = "R7";
    end
    m_pos   = (hb || vb) ? pos + 1 : 0;
    m_armed = m_armed || vfall;
    m_ph    = act ? !m_ph : 1'b0;
    m_hb    = hb;
    m_vb    = vb;
    sb.push_back(e);
    hblank_i = hb; vblank_i = vb; y_i = y; cb_i = cb; cr_i = cr;
  endtask

  task automatic line(bit vb, int n);
    for (int i = 0; i < HBL; i++)
      step(1'b1, vb, 8'(8'hA5 + i), 8'(8'h5A + n), 8'(8'h3C + i));
    for (int i = 0; i < ACT; i++)
      step(1'b0, vb, 8'(n*7 + i*3 + 1), 8'(8'h40 + i*5 + n), 8'(8'hC0 - i*3 - n));
  endtask

  // monitor: one scoreboard item retires per clock
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (yo_o !== e.y || co_o !== e.c) begin
          fails++;
          $display("FAIL %s: yo=%h co=%h expected yo=%h co=%h at %0t",
                   e.req, yo_o, co_o, e.y, e.c, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2);
    checks++;
    if (yo_o !== 8'h00 || co_o !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset: yo=%h co=%h expected 00 00", yo_o, co_o);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: active-looking data before any vblank edge stays silent
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 8'(8'h11 * (i+1)), 8'h22, 8'h33);
    // vertical blanking entered before arming: still silent (R1)
    line(1'b1, 0);
    line(1'b1, 1);
    // vblank falls with hblank: arms, SAV carries AB (R6)
    line(1'b0, 2);
    line(1'b0, 3);
    line(1'b0, 4);
    // vblank rises with hblank: EAV carries B6 (R6), fill through vblank (R7)
    line(1'b1, 5);
    line(1'b1, 6);
    line(1'b0, 7);
    line(1'b0, 8);
    // close with a blanking interval to check R4/R5 after active video
    for (int i = 0; i < HBL; i++) step(1'b1, 1'b0, 8'hEE, 8'hEE, 8'hEE);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule